// File: doc/BRIEF.md
# Smart-Card Serial Receiver with Selectable Oversampling

This block receives asynchronous serial characters on a single data line. It is advanced by a basic-clock enable that pulses a fixed number of times per bit period. In normal mode that number is always 16. In smart-card mode it is one of four ratios, 32, 64, 256 or the non-power-of-two 372, chosen by a 2-bit select.

While idle, the receiver watches the line for a high-to-low transition and zeroes a per-bit tick counter on that transition. It then reads every bit in the middle of its period. A character is ten bits long: a low start bit, eight data bits sent least significant first, and an even-parity bit.

The assembled byte is presented together with a one-cycle valid strobe and a parity error flag. A start bit that reads high at its centre is rejected as noise. The receiver reports this with a one-cycle framing error pulse and returns to idle.

Top module: `scard_rx`

## Requirements
- R1: While reset is held and directly after it, rx_valid, frame_err, parity_err and rx_byte are all zero.
- R2: With card_mode=1, a bit lasts 32, 64, 372 or 256 tick pulses for ratio_sel 00, 01, 10 and 11 respectively.
- R3: With card_mode=0, a bit lasts 16 tick pulses whatever the value of ratio_sel.
- R4: A falling edge of the line seen on a tick starts a character, and every bit is read halfway into its period (on the N/2-th tick of a bit lasting N ticks). A bit value present only within 4 ticks either side of the bit centre is therefore received correctly.
- R5: If the start bit reads high at its centre, frame_err pulses for one cycle, no rx_valid is produced, and the receiver accepts the next proper character.
- R6: Bits 1 to 8 after the start bit are data sent least significant first, and rx_byte shows them once the character completes.
- R7: The tenth bit is even parity. parity_err is 1 when the eight data bits and the parity bit together contain an odd number of ones, and it is updated together with rx_valid.
- R8: rx_valid is high for exactly one clock cycle per character. It rises after the parity bit has been read.
- R9: After the last bit, a new character starts only on a fresh high-to-low transition. If the line stays low after a parity bit of 0, no further character is received.
- R10: The ratio and the mode are captured when the start edge is seen. Changing card_mode or ratio_sel during a character has no effect on that character.
- R11: Only clock cycles with tick high advance the receiver. When tick arrives every k-th clock cycle, bit periods are counted in ticks and the character is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Basic-clock enable, one pulse per basic clock period |
| rxd | input | 1 | Serial receive line, idle high |
| card_mode | input | 1 | 1 = smart-card ratios, 0 = fixed ratio of 16 |
| ratio_sel | input | 2 | Smart-card ratio select (00=32, 01=64, 10=372, 11=256) |
| rx_byte | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe when a character completes |
| parity_err | output | 1 | Even-parity mismatch of the last character |
| frame_err | output | 1 | One-cycle pulse when a false start is rejected |

## Verification
A tick counter that is misaligned to the start edge, or a wrong captured ratio, moves the sample points off-centre. The narrow-window stimulus turns this into a wrong rx_byte within the same character, about ten bit periods after the start edge. A control state that fails to return to idle shows up as a missing rx_valid or frame_err before the next character, or as a second strobe where only one is allowed. Rejection of false starts and the need for a fresh edge are observed at the ports by counting strobes and pulses across glitches and held-low lines.

// File: rtl/scard_rx_pkg.sv
package scard_rx_pkg;

  localparam int RATIO_W      = 9;
  localparam int NORMAL_RATIO = 16;
  localparam int CARD_RATIO0  = 32;
  localparam int CARD_RATIO1  = 64;
  localparam int CARD_RATIO2  = 372;
  localparam int CARD_RATIO3  = 256;

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_START  = 2'd1,
    ST_DATA   = 2'd2,
    ST_PARITY = 2'd3
  } rx_state_e;

  // ticks per bit for a given mode and select
  function automatic ratio_t bit_ratio(input logic card, input logic [1:0] sel);
    ratio_t r;
    if (!card) begin
      r = ratio_t'(NORMAL_RATIO);
    end else begin
      case (sel)
        2'b00:   r = ratio_t'(CARD_RATIO0);
        2'b01:   r = ratio_t'(CARD_RATIO1);
        2'b10:   r = ratio_t'(CARD_RATIO2);
        default: r = ratio_t'(CARD_RATIO3);
      endcase
    end
    return r;
  endfunction

  // counter value at which a bit is latched (N/2-th tick, zero-based)
  function automatic ratio_t centre_count(input ratio_t n);
    return (n >> 1) - ratio_t'(1);
  endfunction

  // last counter value of a bit period
  function automatic ratio_t wrap_count(input ratio_t n);
    return n - ratio_t'(1);
  endfunction

endpackage

// File: rtl/scard_rx_sync.sv
module scard_rx_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain[i] <= RESET_VAL;
        end else if (i == 0) begin
          chain[i] <= d;
        end else begin
          chain[i] <= chain[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/scard_rx_edge.sv
module scard_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else if (tick) begin
      prev_q <= line;
    end
  end

  assign fall = tick & prev_q & ~line;

endmodule

// File: rtl/scard_rx_timer.sv
module scard_rx_timer
  import scard_rx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   arm,
  input  logic   halt,
  input  ratio_t ratio_in,
  output logic   busy,
  output ratio_t ratio_q,
  output logic   mid
);

  ratio_t cnt_q;
  logic   active_q;
  logic   at_wrap;

  assign at_wrap = (cnt_q == wrap_count(ratio_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      ratio_q  <= ratio_t'(NORMAL_RATIO);
    end else if (arm) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      ratio_q  <= ratio_in;
    end else if (halt) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q && tick) begin
      cnt_q <= at_wrap ? '0 : cnt_q + ratio_t'(1);
    end
  end

  assign busy = active_q;
  assign mid  = active_q & tick & (cnt_q == centre_count(ratio_q));

endmodule

// File: rtl/scard_rx_frame.sv
module scard_rx_frame
  import scard_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              mid,
  input  logic              line,
  output logic              arm,
  output logic              halt,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              parity_err,
  output logic              frame_err
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              false_start;
  logic              last_bit;

  assign arm         = (state_q == ST_IDLE) & fall;
  assign false_start = mid & (state_q == ST_START) & line;
  assign last_bit    = mid & (state_q == ST_PARITY);
  assign halt        = false_start | last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      shift_q    <= '0;
      rx_byte    <= '0;
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (arm) state_q <= ST_START;
        end
        ST_START: begin
          if (mid) begin
            if (line) begin
              frame_err <= 1'b1;
              state_q   <= ST_IDLE;
            end else begin
              idx_q   <= '0;
              state_q <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (mid) begin
            shift_q <= {line, shift_q[DATA_W-1:1]};
            if (idx_q == LAST_IDX) begin
              state_q <= ST_PARITY;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        ST_PARITY: begin
          if (mid) begin
            rx_byte    <= shift_q;
            parity_err <= ^{shift_q, line};
            rx_valid   <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scard_rx.sv
module scard_rx
  import scard_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              card_mode,
  input  logic [1:0]        ratio_sel,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              parity_err,
  output logic              frame_err
);

  // named internal events, observed by the bound checker
  logic   line_s;
  logic   fall_w;
  logic   arm_w;
  logic   halt_w;
  logic   busy_w;
  logic   mid_w;
  ratio_t ratio_sel_w;
  ratio_t ratio_q_w;

  assign ratio_sel_w = bit_ratio(card_mode, ratio_sel);

  scard_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd),
    .q     (line_s)
  );

  scard_rx_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .line  (line_s),
    .fall  (fall_w)
  );

  scard_rx_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .arm      (arm_w),
    .halt     (halt_w),
    .ratio_in (ratio_sel_w),
    .busy     (busy_w),
    .ratio_q  (ratio_q_w),
    .mid      (mid_w)
  );

  scard_rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall       (fall_w),
    .mid        (mid_w),
    .line       (line_s),
    .arm        (arm_w),
    .halt       (halt_w),
    .rx_byte    (rx_byte),
    .rx_valid   (rx_valid),
    .parity_err (parity_err),
    .frame_err  (frame_err)
  );

endmodule

// File: rtl/scard_rx_chk.sv
module scard_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       card_mode,
  input logic [1:0] ratio_sel,
  input logic       arm,
  input logic       busy,
  input logic       sample_stb,
  input logic [8:0] n_cur,
  input logic       rx_valid,
  input logic       frame_err
);

  localparam int FRAME_BITS = DATA_W + 2;

  int unsigned tk;
  int unsigned smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tk  <= 0;
      smp <= 0;
    end else if (arm) begin
      tk  <= 0;
      smp <= 0;
    end else begin
      if (busy && tick) tk <= tk + 1;
      if (sample_stb) smp <= smp + 1;
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && frame_err));

  // R4
  centre_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> ((tk % 32'(n_cur)) == 32'(n_cur / 2 - 1)));

  // R6
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (smp == FRAME_BITS));

  // R5
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (smp == 1));

  // R3
  normal_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !card_mode) |=> (n_cur == 9'd16));

  // R2
  card_372_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && card_mode && ratio_sel == 2'b10) |=> (n_cur == 9'd372));

  // R10
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !arm) |=> $stable(n_cur));

  // R11
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !sample_stb);

  // R9
  rearm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> !busy);

endmodule

bind scard_rx scard_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .card_mode  (card_mode),
  .ratio_sel  (ratio_sel),
  .arm        (arm_w),
  .busy       (busy_w),
  .sample_stb (mid_w),
  .n_cur      (ratio_q_w),
  .rx_valid   (rx_valid),
  .frame_err  (frame_err)
);

// File: tb/scard_rx_test.sv
module scard_rx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       card_mode = 1'b0;
  logic [1:0] ratio_sel = 2'b00;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       parity_err;
  logic       frame_err;

  int n_checks = 0;
  int n_fail = 0;
  int valid_seen = 0;
  int ferr_seen = 0;
  logic [7:0] got_byte = 8'h00;
  logic got_perr = 1'b0;
  int tickdiv = 1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scard_rx uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .card_mode(card_mode), .ratio_sel(ratio_sel),
    .rx_byte(rx_byte), .rx_valid(rx_valid),
    .parity_err(parity_err), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        valid_seen++;
        got_byte = rx_byte;
        got_perr = parity_err;
      end
      if (frame_err) ferr_seen++;
    end
  end

  function automatic int exp_ratio(input logic card, input logic [1:0] sel);
    if (!card) return 16;
    return (sel == 2'b10) ? 372 : (32 << sel) * ((sel == 2'b11) ? 2 : 1) / ((sel == 2'b11) ? 2 : 1) * ((sel == 2'b11) ? 1 : 1) + ((sel == 2'b11) ? 0 : 0);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tstep(input logic v);
    for (int c = 0; c < tickdiv; c++) begin
      @(negedge clk);
      tick = (c == 0);
      rxd = v;
    end
  endtask

  // send one character; narrow: each data/parity bit is correct only near its centre
  task automatic send(input logic [7:0] d, input bit bad_par, input int n,
                      input bit narrow, input int gap, input bit swap);
    logic [9:0] bits;
    bits = {(^d) ^ bad_par, d, 1'b0};
    for (int b = 0; b < 10; b++) begin
      for (int t = 0; t < n; t++) begin
        logic v;
        v = bits[b];
        if (narrow && b > 0 && (t < n/2 - 4 || t >= n/2 + 4)) v = ~v;
        if (swap && b == 0 && t == 10) begin
          card_mode = 1'b0;
          ratio_sel = 2'b10;
        end
        tstep(v);
      end
    end
    for (int t = 0; t < gap; t++) tstep(1'b1);
  endtask

  task automatic frame_check(input logic [7:0] d, input bit bad_par, input int n,
                             input bit narrow, input int gap, input string req);
    int v0;
    v0 = valid_seen;
    send(d, bad_par, n, narrow, gap, 1'b0);
    check(valid_seen == v0 + 1, req, "valid count", valid_seen - v0, 1);
    check(got_byte == d, req, "byte", got_byte, d);
    check(got_perr == bad_par, "R7", "parity_err", got_perr, bad_par);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
    check(frame_err == 1'b0, "R1", "frame_err", frame_err, 0);
    check(parity_err == 1'b0, "R1", "parity_err", parity_err, 0);
    check(rx_byte == 8'h00, "R1", "rx_byte", rx_byte, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rx_valid == 1'b0 && rx_byte == 8'h00, "R1", "after release", rx_byte, 0);

    // R3 R4 R6: every byte in normal mode with centre-only windows
    card_mode = 1'b0;
    ratio_sel = 2'b00;
    for (int d = 0; d < 256; d++) frame_check(d[7:0], 1'b0, 16, 1'b1, 32, "R6");

    // R3: select ignored in normal mode
    for (int s = 1; s < 4; s++) begin
      ratio_sel = s[1:0];
      frame_check(8'hA5 ^ s[7:0], 1'b0, 16, 1'b1, 32, "R3");
      frame_check(8'h3C + s[7:0], 1'b1, 16, 1'b1, 32, "R3");
    end

    // R2 card mode ratios
    card_mode = 1'b1;
    for (int s = 0; s < 4; s++) begin
      int n;
      int v0;
      int f0;
      ratio_sel = s[1:0];
      n = exp_ratio(1'b1, s[1:0]);
      check(n == ((s == 0) ? 32 : (s == 1) ? 64 : (s == 2) ? 372 : 256), "R2", "bench ratio", n, 0);
      frame_check(8'h01 << s, 1'b0, n, 1'b1, 2*n, "R2");
      frame_check(8'hF0 ^ s[7:0], 1'b0, n, 1'b1, 2*n, "R4");
      // R7 parity error
      frame_check(8'h5A + s[7:0], 1'b1, n, 1'b0, 2*n, "R7");
      // R5 false start glitch
      v0 = valid_seen;
      f0 = ferr_seen;
      for (int t = 0; t < n/4; t++) tstep(1'b0);
      for (int t = 0; t < 2*n; t++) tstep(1'b1);
      check(ferr_seen == f0 + 1, "R5", "frame_err pulses", ferr_seen - f0, 1);
      check(valid_seen == v0, "R5", "no valid on false start", valid_seen - v0, 0);
      frame_check(8'hC3, 1'b0, n, 1'b0, n, "R5");
      // R8 back to back with one idle bit
      frame_check(8'h81, 1'b0, n, 1'b0, n, "R8");
      frame_check(8'h7E, 1'b0, n, 1'b0, 2*n, "R8");
    end

    // R9: parity bit 0 then line held low: no second character
    begin
      int v0;
      int f0;
      ratio_sel = 2'b00;
      v0 = valid_seen;
      f0 = ferr_seen;
      send(8'h03, 1'b0, 32, 1'b0, 0, 1'b0);
      for (int t = 0; t < 5*32; t++) tstep(1'b0);
      for (int t = 0; t < 12*32; t++) tstep(1'b1);
      check(valid_seen == v0 + 1, "R9", "single valid", valid_seen - v0, 1);
      check(ferr_seen == f0, "R9", "no frame_err", ferr_seen - f0, 0);
      check(got_byte == 8'h03, "R9", "byte", got_byte, 8'h03);
    end

    // R10: mode and ratio changed during the start bit
    begin
      int v0;
      card_mode = 1'b1;
      ratio_sel = 2'b01;
      v0 = valid_seen;
      send(8'h96, 1'b0, 64, 1'b1, 128, 1'b1);
      check(valid_seen == v0 + 1, "R10", "valid count", valid_seen - v0, 1);
      check(got_byte == 8'h96, "R10", "byte", got_byte, 8'h96);
      check(got_perr == 1'b0, "R10", "parity_err", got_perr, 0);
    end

    // R11: tick every third clock
    card_mode = 1'b1;
    ratio_sel = 2'b00;
    tickdiv = 3;
    frame_check(8'h4D, 1'b0, 32, 1'b1, 64, "R11");
    frame_check(8'hB2, 1'b1, 32, 1'b1, 64, "R11");
    tickdiv = 1;

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule